// File: doc/BRIEF.md
# Infrared Receive Byte Buffer with Interrupt Flags

This block sits between an infrared run-length encoder and a host processor. The encoder hands over one byte for each measured pulse or gap, and a strobe at the end of each packet. The block stores these bytes in a first-in first-out buffer whose depth is a parameter, normally 16 or 64. The host reads the bytes back one at a time through a small register window driven by simple read and write strobes.

The same window holds the control, receive and sampling settings that the encoder needs, and an interrupt enable register that also carries a trigger level. A status register gathers three pending flags: overflow, packet end, and data available. It also reports the current fill count. Pending flags are cleared by writing ones. One interrupt line is raised while any enabled flag is pending.

Top module: `ir_rx_fifo_regs`

## Requirements
- R1: After reset every register reads as zero, the fill count is zero and `irq_o` is low.
- R2: Register placement is part of the contract. Offset 0x00 is control: bit 0 is global enable, bit 1 is receive enable, bits 5:4 are mode. Offset 0x10 is receive config: bit 2 is input invert. Offset 0x34 is sampling: bits 7:2 are the noise threshold and bits 15:8 are the idle threshold. Each reads back as written, with unused bits zero, and drives its output pin. `rx_on_o` is global enable AND receive enable.
- R3: Bytes are returned in arrival order. A read at offset 0x20 returns the oldest byte in bits 7:0 and pops it. A read of an empty buffer returns zero and leaves the count at zero.
- R4: While global enable or receive enable is 0, incoming bytes and packet-end strobes are ignored.
- R5: The status register at offset 0x30 reports the fill count in the field starting at bit 8, which is clog2(DEPTH)+1 bits wide.
- R6: A byte that arrives while the buffer is full is dropped, the stored bytes are unchanged, and status bit 0 (overflow) becomes pending.
- R7: A packet-end strobe makes status bit 1 pending.
- R8: Status bit 4 (data available) becomes pending one cycle after the fill count exceeds the trigger level. The trigger level is held in the interrupt enable register at offset 0x2C, from bit 8. A clear has no effect while the condition still holds.
- R9: Writing the status register clears each pending flag whose bit is written as 1. Flags written as 0 keep their state.
- R10: `irq_o` is high exactly when a pending flag has its enable set. The enables are bits 0, 1 and 4 of offset 0x2C.
- R11: While global enable is 0, the buffer is emptied and all pending flags are held clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Byte strobe from the encoder |
| push_data_i | input | 8 | Run-length byte |
| pkt_end_i | input | 1 | Packet-end strobe from the encoder |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the strobe |
| irq_o | output | 1 | Interrupt request |
| rx_on_o | output | 1 | Receive path active |
| mode_o | output | 2 | Mode field to the encoder |
| invert_o | output | 1 | Input polarity invert to the encoder |
| noise_thr_o | output | 6 | Noise threshold to the encoder |
| idle_thr_o | output | 8 | Idle threshold to the encoder |

## Verification
A wrong read or write pointer appears as out-of-order or repeated bytes on the very next pop. A count that drifts from the pointers appears in the status fill field right away. Because the data-available flag is sticky, an error in the count or the comparison leaves a wrong bit 4 and a wrong `irq_o` one cycle after the count crosses the trigger level. The flag then stays wrong until a clear. Random mixes of pushes, pops, clears, level changes and enable toggles are compared against a reference model after every operation, so any such fault shows within two cycles of the operation that exposes it.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_RXCFG = 8'h10;
  localparam logic [7:0] OFS_DATA  = 8'h20;
  localparam logic [7:0] OFS_IEN   = 8'h2C;
  localparam logic [7:0] OFS_STAT  = 8'h30;
  localparam logic [7:0] OFS_SMPL  = 8'h34;

  localparam int B_OVF    = 0;
  localparam int B_PKT    = 1;
  localparam int B_AVL    = 4;
  localparam int FIELD_LO = 8;

  typedef struct packed {
    logic avl;
    logic pkt;
    logic ovf;
  } irq_vec_t;
endpackage

// File: rtl/ir_rx_byte_fifo.sv
module ir_rx_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic [W-1:0]                 data_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 data_o,
  output logic [$clog2(DEPTH):0]       count_o,
  output logic                         drop_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          empty, full, do_pop, do_push;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL);
  assign do_pop  = pop_i & ~empty;
  assign do_push = push_i & (~full | do_pop);
  assign drop_o  = push_i & full & ~do_pop;
  assign data_o  = empty ? '0 : mem[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // storage carries no reset; only accepted bytes are written
  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wp_q] <= data_i;
  end
endmodule

// File: rtl/ir_rx_cfg_regs.sv
module ir_rx_cfg_regs
  import ir_rx_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [7:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic          gen_o,
  output logic          rxen_o,
  output logic [1:0]    mode_o,
  output logic          invert_o,
  output logic [5:0]    noise_o,
  output logic [7:0]    idle_o,
  output irq_vec_t      ien_o,
  output logic [CW-1:0] level_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_o    <= 1'b0;
      rxen_o   <= 1'b0;
      mode_o   <= '0;
      invert_o <= 1'b0;
      noise_o  <= '0;
      idle_o   <= '0;
      ien_o    <= '0;
      level_o  <= '0;
    end else if (wr_i) begin
      case (addr_i)
        OFS_CTRL: begin
          gen_o  <= wdata_i[0];
          rxen_o <= wdata_i[1];
          mode_o <= wdata_i[5:4];
        end
        OFS_RXCFG: invert_o <= wdata_i[2];
        OFS_SMPL: begin
          noise_o <= wdata_i[7:2];
          idle_o  <= wdata_i[15:8];
        end
        OFS_IEN: begin
          ien_o.ovf <= wdata_i[B_OVF];
          ien_o.pkt <= wdata_i[B_PKT];
          ien_o.avl <= wdata_i[B_AVL];
          level_o   <= wdata_i[FIELD_LO +: CW];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ir_rx_irq_ctrl.sv
module ir_rx_irq_ctrl
  import ir_rx_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          ovf_evt_i,
  input  logic          pkt_evt_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] level_i,
  input  irq_vec_t      clr_i,
  input  irq_vec_t      en_i,
  output irq_vec_t      pend_o,
  output logic          irq_o
);
  irq_vec_t set, pend_q;

  always_comb begin
    set.ovf = ovf_evt_i;
    set.pkt = pkt_evt_i;
    set.avl = (count_i > level_i);
  end

  // a fresh event beats a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= '0;
    else if (flush_i) pend_q <= '0;
    else              pend_q <= (pend_q & ~clr_i) | set;
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_i);
endmodule

// File: rtl/ir_rx_fifo_regs.sv
module ir_rx_fifo_regs
  import ir_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  logic [7:0]  push_data_i,
  input  logic        pkt_end_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        rx_on_o,
  output logic [1:0]  mode_o,
  output logic        invert_o,
  output logic [5:0]  noise_thr_o,
  output logic [7:0]  idle_thr_o
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          gen, rxen, acc, flush, pop, drop;
  logic [CW-1:0] fifo_count, level;
  logic [7:0]    head;
  irq_vec_t      ien, pend, clr;

  ir_rx_cfg_regs #(.CW(CW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .gen_o    (gen),
    .rxen_o   (rxen),
    .mode_o   (mode_o),
    .invert_o (invert_o),
    .noise_o  (noise_thr_o),
    .idle_o   (idle_thr_o),
    .ien_o    (ien),
    .level_o  (level)
  );

  assign acc     = gen & rxen;
  assign flush   = ~gen;
  assign rx_on_o = acc;
  assign pop     = rd_i && (addr_i == OFS_DATA);

  always_comb begin
    clr     = '0;
    if (wr_i && addr_i == OFS_STAT) begin
      clr.ovf = wdata_i[B_OVF];
      clr.pkt = wdata_i[B_PKT];
      clr.avl = wdata_i[B_AVL];
    end
  end

  ir_rx_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (push_i & acc),
    .data_i  (push_data_i),
    .pop_i   (pop),
    .data_o  (head),
    .count_o (fifo_count),
    .drop_o  (drop)
  );

  ir_rx_irq_ctrl #(.CW(CW)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush),
    .ovf_evt_i (drop),
    .pkt_evt_i (pkt_end_i & acc),
    .count_i   (fifo_count),
    .level_i   (level),
    .clr_i     (clr),
    .en_i      (ien),
    .pend_o    (pend),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CTRL: begin
        rdata_o[0]   = gen;
        rdata_o[1]   = rxen;
        rdata_o[5:4] = mode_o;
      end
      OFS_RXCFG: rdata_o[2] = invert_o;
      OFS_DATA:  rdata_o[7:0] = head;
      OFS_IEN: begin
        rdata_o[B_OVF]         = ien.ovf;
        rdata_o[B_PKT]         = ien.pkt;
        rdata_o[B_AVL]         = ien.avl;
        rdata_o[FIELD_LO +: CW] = level;
      end
      OFS_STAT: begin
        rdata_o[B_OVF]         = pend.ovf;
        rdata_o[B_PKT]         = pend.pkt;
        rdata_o[B_AVL]         = pend.avl;
        rdata_o[FIELD_LO +: CW] = fifo_count;
      end
      OFS_SMPL: begin
        rdata_o[7:2]  = noise_thr_o;
        rdata_o[15:8] = idle_thr_o;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ir_rx_fifo_chk.sv
module ir_rx_fifo_chk
  import ir_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    push_i,
  input logic                    pkt_end_i,
  input logic                    pop,
  input logic                    gen,
  input logic                    acc,
  input logic [$clog2(DEPTH):0]  fifo_count,
  input logic [$clog2(DEPTH):0]  level,
  input irq_vec_t                pend
);
  localparam int CW = $clog2(DEPTH) + 1;

  assert_count_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_count <= CW'(DEPTH));

  assert_flush_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen |=> (fifo_count == '0) && (pend == '0));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen && push_i && acc && !pop && fifo_count == CW'(DEPTH)) |=> pend.ovf && fifo_count == CW'(DEPTH));

  assert_pkt_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_end_i && acc) |=> pend.pkt);

  assert_avail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen && fifo_count > level) |=> pend.avl);

  assert_ignore_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen && !acc && !pop) |=> $stable(fifo_count));

  assert_empty_pop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && fifo_count == '0 && !(push_i && acc)) |=> fifo_count == '0);
endmodule

bind ir_rx_fifo_regs ir_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .push_i     (push_i),
  .pkt_end_i  (pkt_end_i),
  .pop        (pop),
  .gen        (gen),
  .acc        (acc),
  .fifo_count (fifo_count),
  .level      (level),
  .pend       (pend)
);

// File: tb/sim_ir_rx_fifo_regs.sv
module sim_ir_rx_fifo_regs;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0, pkt = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0]  pdata = '0, addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rx_on, invert;
  logic [1:0]  mode;
  logic [5:0]  noise;
  logic [7:0]  idle;

  always #10 clk = ~clk;

  ir_rx_fifo_regs #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(pdata),
    .pkt_end_i(pkt), .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .rx_on_o(rx_on), .mode_o(mode),
    .invert_o(invert), .noise_thr_o(noise), .idle_thr_o(idle)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic [7:0] q[$];
  logic m_gen = 0, m_rxen = 0, m_ovf = 0, m_pkt = 0, m_avl = 0;
  logic [2:0] m_en = '0;
  int m_lvl = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void settle();
    if (!m_gen) begin
      q.delete();
      m_ovf = 0; m_pkt = 0; m_avl = 0;
    end else if (q.size() > m_lvl) m_avl = 1;
  endfunction

  function automatic logic [31:0] exp_stat();
    return (32'(q.size()) << 8) | {27'd0, m_avl, 2'b00, m_pkt, m_ovf};
  endfunction

  function automatic logic exp_irq();
    return (m_ovf & m_en[0]) | (m_pkt & m_en[1]) | (m_avl & m_en[2]);
  endfunction

  // every operation: drive at negedge, one active edge, one idle edge
  task automatic finish_op();
    @(negedge clk);
    push = 0; pkt = 0; wr = 0; rd = 0;
    @(negedge clk);
  endtask

  task automatic do_wr(logic [7:0] a, logic [31:0] d);
    wr = 1; addr = a; wdata = d;
    finish_op();
    case (a)
      8'h00: begin m_gen = d[0]; m_rxen = d[1]; end
      8'h2C: begin m_en = {d[4], d[1], d[0]}; m_lvl = int'(d[8 +: CW]); end
      8'h30: begin
        if (d[0]) m_ovf = 0;
        if (d[1]) m_pkt = 0;
        if (d[4]) m_avl = 0;
        if (q.size() > m_lvl && m_gen) m_avl = 1;
      end
      default: ;
    endcase
    settle();
  endtask

  task automatic do_rd(logic [7:0] a, output logic [31:0] d);
    rd = 1; addr = a;
    #1 d = rdata;
    finish_op();
    if (a == 8'h20 && q.size() > 0) void'(q.pop_front());
    settle();
  endtask

  task automatic do_push(logic [7:0] b);
    push = 1; pdata = b;
    finish_op();
    if (m_gen && m_rxen) begin
      if (q.size() == DEPTH) m_ovf = 1;
      else q.push_back(b);
    end
    settle();
  endtask

  task automatic do_pkt();
    pkt = 1;
    finish_op();
    if (m_gen && m_rxen) m_pkt = 1;
    settle();
  endtask

  task automatic chk_stat(string req);
    logic [31:0] d;
    do_rd(8'h30, d);
    chk(req, d, exp_stat());
    chk({req, " irq"}, {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  task automatic chk_pop(string req);
    logic [31:0] d;
    logic [31:0] e;
    e = (q.size() > 0) ? {24'd0, q[0]} : 32'd0;
    do_rd(8'h20, d);
    chk(req, d, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1c0de));
    @(negedge clk); @(negedge clk);
    // R1: reset state
    addr = 8'h00; #1 chk("R1 ctrl", rdata, 0);
    addr = 8'h30; #1 chk("R1 stat", rdata, 0);
    addr = 8'h2C; #1 chk("R1 ien", rdata, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: layout and outputs
    do_wr(8'h00, 32'hFFFF_FFF3);
    do_rd(8'h00, d); chk("R2 ctrl", d, 32'h33);
    chk("R2 pins", {26'd0, rx_on, mode, 3'd0}, {26'd0, 1'b1, 2'b11, 3'd0});
    do_wr(8'h10, 32'hFFFF_FFFF);
    do_rd(8'h10, d); chk("R2 rxcfg", d, 32'h4);
    chk("R2 invert", {31'd0, invert}, 1);
    do_wr(8'h34, 32'hFFFF_FFFF);
    do_rd(8'h34, d); chk("R2 smpl", d, 32'hFFFC);
    chk("R2 thr", {18'd0, noise, idle}, {18'd0, 6'h3F, 8'hFF});
    do_wr(8'h2C, 32'h0000_0F00 | 32'h13);
    do_rd(8'h2C, d); chk("R2 ien", d, 32'h0F13);

    // R3: ordering and empty read
    do_push(8'hA5); do_push(8'h3C); do_push(8'h81);
    chk_stat("R5 count 3");
    chk_pop("R3 pop0"); chk_pop("R3 pop1"); chk_pop("R3 pop2");
    do_rd(8'h20, d); chk("R3 empty read", d, 0);
    chk_stat("R3 empty count");

    // R4: receive disabled
    do_wr(8'h00, 32'h31);
    do_push(8'h55); do_pkt();
    chk_stat("R4 ignored");
    do_wr(8'h00, 32'h33);

    // R6: overflow
    for (int i = 0; i < DEPTH + 1; i++) do_push(8'(i + 8'h10));
    chk_stat("R6 full+ovf");
    chk_pop("R6 first kept");
    // R9: clear only overflow
    do_wr(8'h30, 32'h1);
    chk_stat("R9 ovf cleared");
    while (q.size() > 0) chk_pop("R6 drain");

    // R7: packet end
    do_pkt();
    chk_stat("R7 pkt");
    do_wr(8'h30, 32'h2);
    chk_stat("R9 pkt cleared");

    // R8: trigger level 3, sticky against clear while above
    do_wr(8'h2C, 32'h0313);
    do_push(1); do_push(2); do_push(3);
    chk_stat("R8 at level");
    do_push(4);
    chk_stat("R8 above level");
    do_wr(8'h30, 32'h10);
    chk_stat("R8 clear while above");
    chk_pop("R8 pop");
    chk_stat("R8 sticky");
    do_wr(8'h30, 32'h10);
    chk_stat("R9 avl cleared");

    // R10: enable masking
    do_pkt();
    do_wr(8'h2C, 32'h0F01);
    chk_stat("R10 masked");
    do_wr(8'h2C, 32'h0F02);
    chk_stat("R10 enabled");

    // R11: global disable flushes
    do_wr(8'h00, 32'h32);
    chk_stat("R11 flushed");
    do_wr(8'h00, 32'h33);
    chk_stat("R11 empty after enable");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = $urandom_range(0, 19);
      if (op < 7) do_push(8'($urandom));
      else if (op < 11) chk_pop("R3 random pop");
      else if (op < 14) chk_stat("R5 random stat");
      else if (op == 14) do_wr(8'h30, {27'd0, 1'($urandom), 2'd0, 2'($urandom)});
      else if (op == 15) do_pkt();
      else if (op == 16)
        do_wr(8'h2C, (32'($urandom_range(0, DEPTH)) << 8) | {27'd0, 1'($urandom), 2'd0, 2'($urandom)});
      else if (op == 17) begin
        if ($urandom_range(0, 7) == 0) do_wr(8'h00, {28'd0, 2'($urandom), 2'b10});
        else do_wr(8'h00, 32'h33);
      end else begin
        chk("R10 random irq", {31'd0, irq}, {31'd0, exp_irq()});
      end
    end
    chk_stat("R5 final");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule